// File: doc/BRIEF.md
# Banked Program Memory Address Decoder

This block sits between an 8-bit CPU bus and the program memories of a cartridge. It turns CPU addresses in the $6000-$FFFF range into a physical address for a program ROM of up to 1 MB, or into a physical address for work RAM. The work RAM is built from two chips, each holding four 8 KB pages. For every access the block also produces the matching chip enables.

The CPU sets the mapping by writing to a small register set in the $5xxx page:

- A layout register selects how the $8000-$FFFF space is cut into windows.
- A work-RAM page register selects which RAM page appears at $6000-$7FFF.
- Four bank registers supply the page for each switchable window. In each bank register, bit 7 chooses ROM or RAM as the backing memory.

Address decoding is purely combinational. A register write therefore changes the mapping from the very next bus cycle.

The layout register is decoded as an enumerated decode state, and its value names the layout:

- `LAYOUT_ONE32` (0): one 32 KB window.
- `LAYOUT_TWO16` (1): two 16 KB windows.
- `LAYOUT_MIXED` (2): a 16 KB window followed by two 8 KB windows.
- `LAYOUT_FOUR8` (3): four 8 KB windows.

The only transition between layouts is a CPU write to $5100. The next layout is taken from bits 1-0 of the written data. Reset always enters `LAYOUT_FOUR8`.

Each access is also classed into a region state:

- `TGT_NONE`: below $6000.
- `TGT_WRAM`: $6000-$7FFF.
- `TGT_BANKED`: $8000-$FFFF.

Inside a window, the window size is one of `WIN_8K`, `WIN_16K` or `WIN_32K`.

Top module: `prg_bank_decoder`

## Requirements
- R1: Reset state. After reset the layout is 3 (four 8 KB windows), the four bank registers hold $FF and the work-RAM page register holds 0. As a result, a read of $E123 gives rom_addr $FE123, and a read of $6000 enables RAM chip 0, page 0.
- R2: Work-RAM window. An access to $6000-$7FFF always goes to RAM. ram_addr[14:13] takes bits 1-0 of the $5113 register, ram_chip takes bit 2 of it, and ram_addr[12:0] takes cpu_addr[12:0].
- R3: Layout 0. $8000-$FFFF comes from the $5117 register. The two lowest page bits are replaced by cpu_addr[14:13], and rom_addr is {page, cpu_addr[12:0]}.
- R4: Layout 1. $8000-$BFFF comes from $5115 and $C000-$FFFF comes from $5117. In each, the lowest page bit is replaced by cpu_addr[13].
- R5: Layout 2. $8000-$BFFF comes from $5115 as 16 KB, with page bit 0 taken from cpu_addr[13]. $C000-$DFFF comes from $5116 and $E000-$FFFF from $5117, each as 8 KB.
- R6: Layout 3. $8000, $A000, $C000 and $E000 take their 8 KB pages from $5114, $5115, $5116 and $5117 respectively.
- R7: ROM or RAM select. When bit 7 of the selecting bank register is 0, the window goes to RAM. After window alignment, page bits 1-0 drive ram_addr[14:13] and page bit 2 drives ram_chip. A window never enables ROM and RAM together.
- R8: The top register is always ROM. Bit 7 of the $5117 register is ignored, so $5117-backed windows always enable ROM.
- R9: rom_ce is asserted only on reads of a ROM-backed window. A write to a ROM-backed window enables neither memory.
- R10: ram_ce is asserted on a read or a write of a RAM-backed address. ram_we is asserted only on writes.
- R11: No enable is asserted for addresses below $6000. Register writes must match the address exactly, so a write to $5118 changes nothing. Only bits 1-0 of the layout register take effect.
- R12: With neither cpu_rd nor cpu_wr asserted, rom_ce, ram_ce and ram_we are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rd | input | 1 | Read cycle |
| cpu_wr | input | 1 | Write cycle |
| rom_addr | output | 20 | Physical program ROM address |
| rom_ce | output | 1 | ROM enable (reads only) |
| ram_addr | output | 15 | Work-RAM address inside one chip |
| ram_chip | output | 1 | Work-RAM chip select bit |
| ram_ce | output | 1 | Work-RAM enable |
| ram_we | output | 1 | Work-RAM write enable |

## Verification
Two functions meet in consecutive cycles: a bank-register update, and the decode of the first access through the window that register controls. The bench performs the access in the cycle right after the write and expects the new mapping at once. Within a single cycle, a write cycle aimed at a window whose select bit says ROM exercises both the write-gating and the ROM/RAM selection. The bench judges this case by requiring every enable to stay low. It also checks the $5117 case separately: with bit 7 cleared, that window must still enable ROM and never RAM.

// File: rtl/prg_dec_pkg.sv
package prg_dec_pkg;
    localparam int CPU_AW    = 16;
    localparam int WIN_OFS_W = 13;
    localparam logic [CPU_AW-1:0] ADDR_LAYOUT  = 16'h5100;
    localparam logic [CPU_AW-1:0] ADDR_WRAM_PG = 16'h5113;
    localparam logic [CPU_AW-1:0] ADDR_BANK0   = 16'h5114;

    typedef enum logic [1:0] {
        LAYOUT_ONE32 = 2'd0,
        LAYOUT_TWO16 = 2'd1,
        LAYOUT_MIXED = 2'd2,
        LAYOUT_FOUR8 = 2'd3
    } layout_e;

    typedef enum logic [1:0] {
        WIN_8K  = 2'd0,
        WIN_16K = 2'd1,
        WIN_32K = 2'd2
    } win_e;

    typedef enum logic [1:0] {
        TGT_NONE   = 2'd0,
        TGT_WRAM   = 2'd1,
        TGT_BANKED = 2'd2
    } region_e;
endpackage

// File: rtl/prg_regs.sv
module prg_regs
    import prg_dec_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int NUM_BANKS = 4,
    parameter int RAM_SEL_W = 3
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic [CPU_AW-1:0]                   cpu_addr,
    input  logic [DATA_W-1:0]                   cpu_wdata,
    input  logic                                cpu_wr,
    output layout_e                             layout,
    output logic [RAM_SEL_W-1:0]                wram_sel,
    output logic [NUM_BANKS-1:0][DATA_W-1:0]    bank_q
);
    logic [1:0]           layout_q;
    logic [RAM_SEL_W-1:0] wram_q;

    // Layout register: reset enters the four-window layout.
    always_ff @(posedge clk) begin
        if (!rst_n)
            layout_q <= 2'd3;
        else if (cpu_wr && cpu_addr == ADDR_LAYOUT)
            layout_q <= cpu_wdata[1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            wram_q <= '0;
        else if (cpu_wr && cpu_addr == ADDR_WRAM_PG)
            wram_q <= cpu_wdata[RAM_SEL_W-1:0];
    end

    genvar g;
    generate
        for (g = 0; g < NUM_BANKS; g++) begin : g_bank
            localparam logic [CPU_AW-1:0] MY_ADDR = ADDR_BANK0 + CPU_AW'(g);
            logic [DATA_W-1:0] q;
            always_ff @(posedge clk) begin
                if (!rst_n)
                    q <= '1;
                else if (cpu_wr && cpu_addr == MY_ADDR)
                    q <= cpu_wdata;
            end
            assign bank_q[g] = q;
        end
    endgenerate

    assign layout   = layout_e'(layout_q);
    assign wram_sel = wram_q;
endmodule

// File: rtl/prg_window_map.sv
module prg_window_map
    import prg_dec_pkg::*;
#(
    parameter int IDX_W = 2
) (
    input  layout_e          layout,
    input  logic [1:0]       slot,
    output logic [IDX_W-1:0] bank_idx,
    output win_e             win
);
    localparam logic [IDX_W-1:0] IDX_TOP = '1;
    localparam logic [IDX_W-1:0] IDX_B1  = IDX_W'(1);

    always_comb begin
        unique case (layout)
            LAYOUT_ONE32: begin
                bank_idx = IDX_TOP;
                win      = WIN_32K;
            end
            LAYOUT_TWO16: begin
                bank_idx = slot[1] ? IDX_TOP : IDX_B1;
                win      = WIN_16K;
            end
            LAYOUT_MIXED: begin
                if (!slot[1]) begin
                    bank_idx = IDX_B1;
                    win      = WIN_16K;
                end else begin
                    bank_idx = IDX_W'({1'b1, slot[0]});
                    win      = WIN_8K;
                end
            end
            LAYOUT_FOUR8: begin
                bank_idx = IDX_W'(slot);
                win      = WIN_8K;
            end
            default: begin
                bank_idx = IDX_TOP;
                win      = WIN_8K;
            end
        endcase
    end
endmodule

// File: rtl/prg_addr_form.sv
module prg_addr_form
    import prg_dec_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int NUM_BANKS  = 4,
    parameter int RAM_PAGE_W = 2,
    parameter int IDX_W      = 2
) (
    input  logic [CPU_AW-1:0]                cpu_addr,
    input  logic                             cpu_rd,
    input  logic                             cpu_wr,
    input  logic [RAM_PAGE_W:0]              wram_sel,
    input  logic [NUM_BANKS-1:0][DATA_W-1:0] bank_q,
    input  logic [IDX_W-1:0]                 bank_idx,
    input  win_e                             win,
    output logic [DATA_W-2+WIN_OFS_W:0]      rom_addr,
    output logic                             rom_ce,
    output logic [RAM_PAGE_W+WIN_OFS_W-1:0]  ram_addr,
    output logic                             ram_chip,
    output logic                             ram_ce,
    output logic                             ram_we
);
    localparam int PAGE_W = DATA_W - 1;
    localparam logic [IDX_W-1:0] IDX_TOP = IDX_W'(NUM_BANKS - 1);

    region_e             region;
    logic [DATA_W-1:0]   sel_byte;
    logic [PAGE_W-1:0]   page;
    logic [PAGE_W-1:0]   eff_page;
    logic                rom_pick;
    logic [RAM_PAGE_W:0] ram_bits;
    logic                use_rom;
    logic                use_ram;

    always_comb begin
        if (cpu_addr[15])
            region = TGT_BANKED;
        else if (cpu_addr[14:13] == 2'b11)
            region = TGT_WRAM;
        else
            region = TGT_NONE;
    end

    assign sel_byte = bank_q[bank_idx];
    assign page     = sel_byte[PAGE_W-1:0];
    // The top register can never hand its window to RAM.
    assign rom_pick = sel_byte[PAGE_W] || (bank_idx == IDX_TOP);

    always_comb begin
        unique case (win)
            WIN_8K:  eff_page = page;
            WIN_16K: eff_page = {page[PAGE_W-1:1], cpu_addr[13]};
            WIN_32K: eff_page = {page[PAGE_W-1:2], cpu_addr[14:13]};
            default: eff_page = page;
        endcase
    end

    always_comb begin
        unique case (region)
            TGT_WRAM: begin
                use_rom  = 1'b0;
                use_ram  = 1'b1;
                ram_bits = wram_sel;
            end
            TGT_BANKED: begin
                use_rom  = rom_pick;
                use_ram  = !rom_pick;
                ram_bits = eff_page[RAM_PAGE_W:0];
            end
            default: begin
                use_rom  = 1'b0;
                use_ram  = 1'b0;
                ram_bits = '0;
            end
        endcase
    end

    assign rom_addr = {eff_page, cpu_addr[WIN_OFS_W-1:0]};
    assign ram_addr = {ram_bits[RAM_PAGE_W-1:0], cpu_addr[WIN_OFS_W-1:0]};
    assign ram_chip = ram_bits[RAM_PAGE_W];
    assign rom_ce   = use_rom && cpu_rd;
    assign ram_ce   = use_ram && (cpu_rd || cpu_wr);
    assign ram_we   = use_ram && cpu_wr;
endmodule

// File: rtl/prg_bank_decoder.sv
module prg_bank_decoder
    import prg_dec_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int NUM_BANKS  = 4,
    parameter int RAM_PAGE_W = 2,
    parameter int ROM_AW     = DATA_W - 1 + WIN_OFS_W,
    parameter int RAM_AW     = RAM_PAGE_W + WIN_OFS_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [15:0]       cpu_addr,
    input  logic [7:0]        cpu_wdata,
    input  logic              cpu_rd,
    input  logic              cpu_wr,
    output logic [ROM_AW-1:0] rom_addr,
    output logic              rom_ce,
    output logic [RAM_AW-1:0] ram_addr,
    output logic              ram_chip,
    output logic              ram_ce,
    output logic              ram_we
);
    localparam int IDX_W = $clog2(NUM_BANKS);

    layout_e                          layout;
    logic [RAM_PAGE_W:0]              wram_sel;
    logic [NUM_BANKS-1:0][DATA_W-1:0] bank_q;
    logic [IDX_W-1:0]                 bank_idx;
    win_e                             win;

    prg_regs #(
        .DATA_W(DATA_W), .NUM_BANKS(NUM_BANKS), .RAM_SEL_W(RAM_PAGE_W + 1)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_wr(cpu_wr), .layout(layout), .wram_sel(wram_sel), .bank_q(bank_q)
    );

    prg_window_map #(.IDX_W(IDX_W)) u_map (
        .layout(layout), .slot(cpu_addr[14:13]), .bank_idx(bank_idx), .win(win)
    );

    prg_addr_form #(
        .DATA_W(DATA_W), .NUM_BANKS(NUM_BANKS), .RAM_PAGE_W(RAM_PAGE_W), .IDX_W(IDX_W)
    ) u_form (
        .cpu_addr(cpu_addr), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .wram_sel(wram_sel),
        .bank_q(bank_q), .bank_idx(bank_idx), .win(win),
        .rom_addr(rom_addr), .rom_ce(rom_ce), .ram_addr(ram_addr),
        .ram_chip(ram_chip), .ram_ce(ram_ce), .ram_we(ram_we)
    );
endmodule

// File: rtl/prg_bank_decoder_chk.sv
module prg_bank_decoder_chk #(
    parameter int ROM_AW = 20,
    parameter int RAM_AW = 15
) (
    input logic              clk,
    input logic              rst_n,
    input logic [15:0]       cpu_addr,
    input logic [7:0]        cpu_wdata,
    input logic              cpu_rd,
    input logic              cpu_wr,
    input logic [ROM_AW-1:0] rom_addr,
    input logic              rom_ce,
    input logic [RAM_AW-1:0] ram_addr,
    input logic              ram_chip,
    input logic              ram_ce,
    input logic              ram_we
);
    p_wram_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && cpu_addr[15:13] == 3'b011) |-> ram_we);
    p_ram_offset_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ram_ce |-> (ram_addr[12:0] == cpu_addr[12:0]));
    p_one_memory_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(rom_ce && ram_ce));
    p_top_is_rom_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_rd && cpu_addr[15:13] == 3'b111) |-> (rom_ce && rom_addr[12:0] == cpu_addr[12:0]));
    p_rom_on_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rom_ce |-> (cpu_rd && cpu_addr[15]));
    p_we_on_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> (ram_ce && cpu_wr));
    p_low_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_addr < 16'h6000) |-> (!rom_ce && !ram_ce && !ram_we));
    p_idle_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (!cpu_rd && !cpu_wr) |-> (!rom_ce && !ram_ce && !ram_we));
endmodule

bind prg_bank_decoder prg_bank_decoder_chk #(.ROM_AW(ROM_AW), .RAM_AW(RAM_AW)) u_chk (.*);

// File: tb/prg_bank_decoder_bench.sv
module prg_bank_decoder_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic [7:0]  cpu_wdata = '0;
    logic        cpu_rd = 1'b0;
    logic        cpu_wr = 1'b0;
    logic [19:0] rom_addr;
    logic        rom_ce;
    logic [14:0] ram_addr;
    logic        ram_chip;
    logic        ram_ce;
    logic        ram_we;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    prg_bank_decoder u_prg_bank_decoder (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .rom_addr(rom_addr), .rom_ce(rom_ce),
        .ram_addr(ram_addr), .ram_chip(ram_chip), .ram_ce(ram_ce), .ram_we(ram_we)
    );

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    task automatic reg_write(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1; cpu_rd = 1'b0;
        @(negedge clk);
        cpu_wr = 1'b0;
    endtask

    task automatic probe(input logic [15:0] a, input logic rd, input logic wr);
        cpu_addr = a; cpu_rd = rd; cpu_wr = wr;
        #2;
    endtask

    task automatic rom_read(input string req, input logic [15:0] a, input logic [19:0] exp);
        probe(a, 1'b1, 1'b0);
        chk({req, " rom_ce"}, 32'(rom_ce), 32'd1);
        chk({req, " ram_ce"}, 32'(ram_ce), 32'd0);
        chk({req, " rom_addr"}, 32'(rom_addr), 32'(exp));
    endtask

    task automatic t_reset;
        rom_read("R1 top", 16'hE123, 20'hFE123);
        rom_read("R1 low", 16'h8000, 20'hFE000);
        probe(16'h6000, 1'b1, 1'b0);
        chk("R1 wram ce", 32'(ram_ce), 32'd1);
        chk("R1 wram addr", 32'({ram_chip, ram_addr}), 32'd0);
    endtask

    task automatic t_wram;
        reg_write(16'h5113, 8'h06);
        probe(16'h7ABC, 1'b0, 1'b1);
        chk("R2 we", 32'(ram_we), 32'd1);
        chk("R2 addr", 32'(ram_addr), 32'h5ABC);
        chk("R2 chip", 32'(ram_chip), 32'd1);
        probe(16'h7ABC, 1'b1, 1'b0);
        chk("R10 read ce", 32'(ram_ce), 32'd1);
        chk("R10 read no we", 32'(ram_we), 32'd0);
    endtask

    task automatic t_layout0;
        reg_write(16'h5100, 8'h00);
        reg_write(16'h5117, 8'h8B);
        rom_read("R3 8000", 16'h8000, 20'h10000);
        rom_read("R3 C001", 16'hC001, 20'h14001);
        rom_read("R3 FFFF", 16'hFFFF, 20'h17FFF);
    endtask

    task automatic t_layout1;
        reg_write(16'h5100, 8'h01);
        reg_write(16'h5115, 8'h85);
        reg_write(16'h5117, 8'h93);
        rom_read("R4 8000", 16'h8000, 20'h08000);
        rom_read("R4 A010", 16'hA010, 20'h0A010);
        rom_read("R4 C000", 16'hC000, 20'h24000);
        rom_read("R4 E000", 16'hE000, 20'h26000);
    endtask

    task automatic t_layout2;
        reg_write(16'h5100, 8'h02);
        reg_write(16'h5115, 8'h87);
        reg_write(16'h5116, 8'hC4);
        reg_write(16'h5117, 8'h9F);
        rom_read("R5 8000", 16'h8000, 20'h0C000);
        rom_read("R5 A000", 16'hA000, 20'h0E000);
        rom_read("R5 C005", 16'hC005, 20'h88005);
        rom_read("R5 E000", 16'hE000, 20'h3E000);
    endtask

    task automatic t_layout3;
        reg_write(16'h5100, 8'h03);
        reg_write(16'h5114, 8'h81);
        reg_write(16'h5115, 8'h82);
        reg_write(16'h5116, 8'h83);
        reg_write(16'h5117, 8'h84);
        rom_read("R6 8000", 16'h8000, 20'h02000);
        rom_read("R6 A000", 16'hA000, 20'h04000);
        rom_read("R6 C000", 16'hC000, 20'h06000);
        rom_read("R6 E000", 16'hE000, 20'h08000);
    endtask

    task automatic t_ram_window;
        reg_write(16'h5115, 8'h05);
        probe(16'hA123, 1'b0, 1'b1);
        chk("R7 8k we", 32'(ram_we), 32'd1);
        chk("R7 8k rom off", 32'(rom_ce), 32'd0);
        chk("R7 8k addr", 32'({ram_chip, ram_addr}), 32'h0A123);
        reg_write(16'h5100, 8'h01);
        reg_write(16'h5115, 8'h02);
        probe(16'hA004, 1'b1, 1'b0);
        chk("R7 16k ce", 32'(ram_ce), 32'd1);
        chk("R7 16k addr", 32'({ram_chip, ram_addr}), 32'h06004);
        probe(16'h8004, 1'b1, 1'b0);
        chk("R7 16k low addr", 32'({ram_chip, ram_addr}), 32'h04004);
    endtask

    task automatic t_top_rom;
        reg_write(16'h5100, 8'h03);
        reg_write(16'h5117, 8'h05);
        rom_read("R8 E000", 16'hE000, 20'h0A000);
        probe(16'hE000, 1'b0, 1'b1);
        chk("R8 write no ram", 32'({ram_ce, ram_we}), 32'd0);
    endtask

    task automatic t_rom_write;
        reg_write(16'h5114, 8'h81);
        probe(16'h8000, 1'b0, 1'b1);
        chk("R9 rom_ce", 32'(rom_ce), 32'd0);
        chk("R9 ram", 32'({ram_ce, ram_we}), 32'd0);
    endtask

    task automatic t_misc;
        reg_write(16'h5117, 8'h84);
        reg_write(16'h5118, 8'h00);
        rom_read("R11 5118 ignored", 16'hE000, 20'h08000);
        reg_write(16'h5115, 8'h80);
        reg_write(16'h5116, 8'h81);
        reg_write(16'h5100, 8'hFE);
        rom_read("R11 layout low bits", 16'hA000, 20'h02000);
        probe(16'h4000, 1'b1, 1'b0);
        chk("R11 below 6000 rd", 32'({rom_ce, ram_ce}), 32'd0);
        probe(16'h5FFF, 1'b0, 1'b0);
        probe(16'h5FFF, 1'b0, 1'b1);
        chk("R11 below 6000 wr", 32'({ram_ce, ram_we}), 32'd0);
        cpu_wr = 1'b0;
    endtask

    task automatic t_idle;
        probe(16'h6000, 1'b0, 1'b0);
        chk("R12 idle wram", 32'({rom_ce, ram_ce, ram_we}), 32'd0);
        probe(16'hE000, 1'b0, 1'b0);
        chk("R12 idle rom", 32'({rom_ce, ram_ce, ram_we}), 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_wram();
        t_layout0();
        t_layout1();
        t_layout2();
        t_layout3();
        t_ram_window();
        t_top_rom();
        t_rom_write();
        t_misc();
        t_idle();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule